// File: doc/BRIEF.md
# Configuration file payload locator

This block watches a configuration file as it streams in, one byte per accepted cycle. It finds the offset where the configuration payload begins, and it forwards only the bytes from that offset onward. A counter inside the block numbers each byte, starting at zero when `start_i` is pulsed. A header walker steps over a fixed number of length-prefixed descriptive fields that begin at a fixed offset. A preamble matcher then applies one of two rules, and `mode_i` chooses the rule at the start of each file. The raw rule looks for a run of four 0xFF bytes after the header. The packed rule looks, from offset zero onward, for a 0xFF byte followed by a byte whose upper nibble is 3.

The match may be decided only after some bytes that belong to the payload have already been seen. To handle this, every byte passes through a three-entry window that also serves as a fixed delay line. The payload output therefore trails the input by three accepted bytes. After the final byte, three flush cycles drain the window. The block reports the payload start offset, or it raises a not-found flag once the file ends without a match.

Top module: `bsl_top`

## Requirements
- R1: The header walk begins at byte offset 15 and skips exactly 4 fields. The first byte of each field is a length L, and the next field begins at the current field offset + L + 3. In raw mode, bytes before the end of the fourth field can never form part of a preamble.
- R2: In raw mode (mode_i = 0), the preamble is four consecutive 0xFF bytes, all at or after the end of the header. The payload start offset is the index of the first of these four bytes. Only the first such run counts.
- R3: In packed mode (mode_i = 1), the preamble is a 0xFF byte at any index i from 0 onward, followed at i+1 by a byte whose bits [7:4] equal 4'h3. The payload start offset is i+2. A 0xFF that is the last byte of the file cannot match. Only the first such pair counts.
- R4: Each byte whose index is at or above the payload start offset appears exactly once on pay_byte_o, together with its index on pay_idx_o, in index order, while pay_vld_o is 1. No other byte appears. The byte with index k appears one cycle after the edge that accepts byte k+3, or one cycle after flush cycle 1, 2 or 3 following the last byte. On all other cycles pay_vld_o is 0.
- R5: found_o and start_off_o update on the edge that accepts the detecting byte: the fourth 0xFF in raw mode, or the nibble-3 byte in packed mode. Both hold until the next start_i.
- R6: miss_o rises on the edge that accepts the last byte (last_i = 1) when no preamble has been found by then. miss_o and found_o are never both 1.
- R7: Reset, and each start_i pulse, clear found_o, start_off_o, miss_o and pay_vld_o, and restart byte numbering at 0. start_i takes priority over a byte offered in the same cycle, and that byte is dropped.
- R8: mode_i is sampled only when start_i is 1. Cycles with byte_vld_i = 0 have no effect. Bytes offered after the last byte of a file, up to the next start_i, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new file; clears state and latches mode_i |
| mode_i | input | 1 | Preamble rule: 0 raw, 1 packed |
| byte_vld_i | input | 1 | byte_i carries a file byte this cycle |
| byte_i | input | 8 | File byte |
| last_i | input | 1 | The byte offered is the last byte of the file |
| pay_vld_o | output | 1 | pay_byte_o carries a payload byte |
| pay_byte_o | output | 8 | Payload byte |
| pay_idx_o | output | IDX_W | File index of pay_byte_o |
| found_o | output | 1 | A preamble has been found |
| start_off_o | output | IDX_W | Payload start offset, valid while found_o is 1 |
| miss_o | output | 1 | The file ended without a preamble |

## Verification
The results are due at different times:
- A payload byte is due on the cycle after the edge that accepts the byte three positions after it, or after the matching flush cycle.
- found_o and start_off_o are due right after the detecting byte is accepted.
- miss_o is due right after the last byte is accepted.

The bench steps a behavioural model once per cycle. The model is a three-slot queue of indices, together with a detection index worked out from the file contents. The model is stepped using the same inputs the design samples at that edge. All outputs are compared at the following falling edge, so each result is checked in exactly the cycle it is due. The stimulus includes idle gaps, a mode flip in the middle of a file, and junk bytes during the flush, which confirm that the timing holds under those conditions.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic {
    LOAD_RAW    = 1'b0,
    LOAD_PACKED = 1'b1
  } load_mode_e;

  localparam logic [7:0] PRE_BYTE   = 8'hFF;
  localparam logic [3:0] PACK_NIBLE = 4'h3;
endpackage

// File: rtl/bsl_hdr_walk.sv
module bsl_hdr_walk #(
  parameter int IDX_W       = 16,
  parameter int HDR_OFF     = 15,
  parameter int N_FIELDS    = 4,
  parameter int FIELD_EXTRA = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic [7:0]       data_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             done_o,
  output logic [IDX_W-1:0] body_off_o
);
  localparam int CNT_W = $clog2(N_FIELDS + 1);

  logic [IDX_W-1:0] nxt_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o     = (cnt_q == CNT_W'(N_FIELDS));
  assign body_off_o = nxt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= IDX_W'(HDR_OFF);
      cnt_q <= '0;
    end else if (clr_i) begin
      nxt_q <= IDX_W'(HDR_OFF);
      cnt_q <= '0;
    end else if (acc_i && !done_o && (idx_i == nxt_q)) begin
      // length byte of current field
      nxt_q <= nxt_q + IDX_W'(data_i) + IDX_W'(FIELD_EXTRA);
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bsl_window.sv
module bsl_window #(
  parameter int IDX_W = 16,
  parameter int DEPTH = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  shift_i,
  input  logic                  in_vld_i,
  input  logic                  in_elig_i,
  input  logic [IDX_W-1:0]      in_idx_i,
  input  logic [7:0]            in_dat_i,
  output logic [DEPTH-1:0]      vld_o,
  output logic [DEPTH-1:0]      elig_o,
  output logic [DEPTH-1:0][7:0] dat_o,
  output logic [IDX_W-1:0]      old_idx_o
);
  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0]            elig_q;
  logic [DEPTH-1:0][7:0]       dat_q;
  logic [DEPTH-1:0][IDX_W-1:0] idx_q;

  assign vld_o     = vld_q;
  assign elig_o    = elig_q;
  assign dat_o     = dat_q;
  assign old_idx_o = idx_q[DEPTH-1];

  // entry 0 newest, entry DEPTH-1 oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      elig_q <= '0;
      dat_q  <= '0;
      idx_q  <= '0;
    end else if (clr_i) begin
      vld_q  <= '0;
      elig_q <= '0;
    end else if (shift_i) begin
      for (int i = DEPTH - 1; i > 0; i--) begin
        vld_q[i]  <= vld_q[i-1];
        elig_q[i] <= elig_q[i-1];
        dat_q[i]  <= dat_q[i-1];
        idx_q[i]  <= idx_q[i-1];
      end
      vld_q[0]  <= in_vld_i;
      elig_q[0] <= in_elig_i;
      dat_q[0]  <= in_dat_i;
      idx_q[0]  <= in_idx_i;
    end
  end
endmodule

// File: rtl/bsl_match.sv
module bsl_match
  import bsl_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int DEPTH = 3
) (
  input  logic                  acc_i,
  input  load_mode_e            mode_i,
  input  logic [7:0]            data_i,
  input  logic                  new_elig_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [DEPTH-1:0]      w_vld_i,
  input  logic [DEPTH-1:0]      w_elig_i,
  input  logic [DEPTH-1:0][7:0] w_dat_i,
  input  logic [IDX_W-1:0]      old_idx_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      hit_off_o
);
  logic [DEPTH-1:0] ff_ok;
  logic             raw_hit, pk_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ff
    assign ff_ok[g] = w_vld_i[g] && w_elig_i[g] && (w_dat_i[g] == PRE_BYTE);
  end

  assign raw_hit = (&ff_ok) && new_elig_i && (data_i == PRE_BYTE);
  assign pk_hit  = w_vld_i[0] && (w_dat_i[0] == PRE_BYTE) && (data_i[7:4] == PACK_NIBLE);

  always_comb begin
    hit_o     = 1'b0;
    hit_off_o = '0;
    unique case (mode_i)
      LOAD_RAW: begin
        hit_o     = acc_i && raw_hit;
        hit_off_o = old_idx_i;
      end
      LOAD_PACKED: begin
        hit_o     = acc_i && pk_hit;
        hit_off_o = idx_i + 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsl_gate.sv
module bsl_gate #(
  parameter int IDX_W = 16,
  parameter int DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic             last_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] hit_off_i,
  input  logic             old_vld_i,
  input  logic [IDX_W-1:0] old_idx_i,
  input  logic [7:0]       old_dat_i,
  output logic             flush_o,
  output logic             ended_o,
  output logic             pay_vld_o,
  output logic [7:0]       pay_byte_o,
  output logic [IDX_W-1:0] pay_idx_o,
  output logic             found_o,
  output logic [IDX_W-1:0] start_off_o,
  output logic             miss_o
);
  localparam int FC_W = $clog2(DEPTH + 1);

  logic [FC_W-1:0]  fcnt_q;
  logic             ended_q, found_q, miss_q, pay_vld_q;
  logic [IDX_W-1:0] start_q, pay_idx_q;
  logic [7:0]       pay_dat_q;
  logic             shift, emit, in_pay;

  assign flush_o = (fcnt_q != '0);
  assign ended_o = ended_q;
  assign shift   = acc_i || flush_o;
  // uncompressed hit releases its first payload byte in the same cycle
  assign in_pay  = found_q ? (old_idx_i >= start_q) : (hit_i && (old_idx_i >= hit_off_i));
  assign emit    = shift && old_vld_i && in_pay;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q    <= '0;
      ended_q   <= 1'b0;
      found_q   <= 1'b0;
      miss_q    <= 1'b0;
      start_q   <= '0;
      pay_vld_q <= 1'b0;
      pay_idx_q <= '0;
      pay_dat_q <= '0;
    end else if (clr_i) begin
      fcnt_q    <= '0;
      ended_q   <= 1'b0;
      found_q   <= 1'b0;
      miss_q    <= 1'b0;
      start_q   <= '0;
      pay_vld_q <= 1'b0;
    end else begin
      pay_vld_q <= emit;
      if (emit) begin
        pay_idx_q <= old_idx_i;
        pay_dat_q <= old_dat_i;
      end
      if (acc_i && hit_i && !found_q) begin
        found_q <= 1'b1;
        start_q <= hit_off_i;
      end
      if (acc_i && last_i) begin
        ended_q <= 1'b1;
        fcnt_q  <= FC_W'(DEPTH);
        if (!found_q && !hit_i) miss_q <= 1'b1;
      end else if (flush_o) begin
        fcnt_q <= fcnt_q - 1'b1;
      end
    end
  end

  assign pay_vld_o   = pay_vld_q;
  assign pay_byte_o  = pay_dat_q;
  assign pay_idx_o   = pay_idx_q;
  assign found_o     = found_q;
  assign start_off_o = start_q;
  assign miss_o      = miss_q;
endmodule

// File: rtl/bsl_top.sv
module bsl_top
  import bsl_pkg::*;
#(
  parameter int IDX_W       = 16,
  parameter int HDR_OFF     = 15,
  parameter int N_FIELDS    = 4,
  parameter int FIELD_EXTRA = 3,
  parameter int PRE_RUN     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             last_i,
  output logic             pay_vld_o,
  output logic [7:0]       pay_byte_o,
  output logic [IDX_W-1:0] pay_idx_o,
  output logic             found_o,
  output logic [IDX_W-1:0] start_off_o,
  output logic             miss_o
);
  localparam int DEPTH = PRE_RUN - 1;

  load_mode_e             mode_q;
  logic [IDX_W-1:0]       idx_q;
  logic                   acc, ended, flush, shift;
  logic                   hdr_done, new_elig;
  logic [IDX_W-1:0]       body_off;
  logic [DEPTH-1:0]       w_vld, w_elig;
  logic [DEPTH-1:0][7:0]  w_dat;
  logic [IDX_W-1:0]       old_idx;
  logic                   hit;
  logic [IDX_W-1:0]       hit_off;

  assign acc      = byte_vld_i && !start_i && !ended;
  assign shift    = acc || flush;
  assign new_elig = hdr_done && (idx_q >= body_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= LOAD_RAW;
      idx_q  <= '0;
    end else if (start_i) begin
      mode_q <= load_mode_e'(mode_i);
      idx_q  <= '0;
    end else if (acc) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  bsl_hdr_walk #(
    .IDX_W(IDX_W), .HDR_OFF(HDR_OFF), .N_FIELDS(N_FIELDS), .FIELD_EXTRA(FIELD_EXTRA)
  ) u_hdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i), .acc_i(acc),
    .data_i(byte_i), .idx_i(idx_q), .done_o(hdr_done), .body_off_o(body_off)
  );

  bsl_window #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i), .shift_i(shift),
    .in_vld_i(acc), .in_elig_i(new_elig), .in_idx_i(idx_q), .in_dat_i(byte_i),
    .vld_o(w_vld), .elig_o(w_elig), .dat_o(w_dat), .old_idx_o(old_idx)
  );

  bsl_match #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_match (
    .acc_i(acc), .mode_i(mode_q), .data_i(byte_i), .new_elig_i(new_elig),
    .idx_i(idx_q), .w_vld_i(w_vld), .w_elig_i(w_elig), .w_dat_i(w_dat),
    .old_idx_i(old_idx), .hit_o(hit), .hit_off_o(hit_off)
  );

  bsl_gate #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i), .acc_i(acc), .last_i(last_i),
    .hit_i(hit), .hit_off_i(hit_off), .old_vld_i(w_vld[DEPTH-1]),
    .old_idx_i(old_idx), .old_dat_i(w_dat[DEPTH-1]),
    .flush_o(flush), .ended_o(ended),
    .pay_vld_o(pay_vld_o), .pay_byte_o(pay_byte_o), .pay_idx_o(pay_idx_o),
    .found_o(found_o), .start_off_o(start_off_o), .miss_o(miss_o)
  );
endmodule

// File: rtl/bsl_chk.sv
module bsl_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             pay_vld_o,
  input logic [IDX_W-1:0] pay_idx_o,
  input logic             found_o,
  input logic [IDX_W-1:0] start_off_o,
  input logic             miss_o
);
  // R4
  pay_after_found_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_vld_o |-> found_o);

  // R4
  pay_above_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_vld_o |-> (pay_idx_o >= start_off_o));

  // R4
  pay_in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_vld_o && $past(pay_vld_o)) |-> (pay_idx_o == IDX_W'($past(pay_idx_o) + 1'b1)));

  // R5
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o && !start_i) |=> (found_o && $stable(start_off_o)));

  // R6
  miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !found_o);

  // R7
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!found_o && !miss_o && !pay_vld_o));
endmodule

bind bsl_top bsl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pay_vld_o(pay_vld_o),
  .pay_idx_o(pay_idx_o), .found_o(found_o), .start_off_o(start_off_o), .miss_o(miss_o)
);

// File: tb/tb_bsl_top.sv
module tb_bsl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, mode_i = 1'b0, byte_vld_i = 1'b0, last_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        pay_vld_o, found_o, miss_o;
  logic [7:0]  pay_byte_o;
  logic [15:0] pay_idx_o, start_off_o;

  always #2 clk = ~clk;

  bsl_top dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .last_i(last_i),
    .pay_vld_o(pay_vld_o), .pay_byte_o(pay_byte_o), .pay_idx_o(pay_idx_o),
    .found_o(found_o), .start_off_o(start_off_o), .miss_o(miss_o)
  );

  int checks = 0, errors = 0;
  bit fin = 0;
  logic [7:0] fbuf[$];
  bit ref_found;
  int ref_start, det_idx;

  int dq[$];
  int n_acc, m_flush, emitted;
  bit m_end, e_vld, e_found, e_miss;
  logic [7:0] e_byte;
  int e_idx, e_off;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add(logic [7:0] b);
    fbuf.push_back(b);
  endtask

  // 15 leading bytes then four length-prefixed fields
  task automatic hdr(int l0, int l1, int l2, int l3, logic [7:0] fill_last);
    int lens[4];
    lens = '{l0, l1, l2, l3};
    fbuf.delete();
    for (int i = 0; i < 15; i++)
      add((i == 3 || (i >= 7 && i <= 10)) ? 8'hFF : (i == 4) ? 8'h3C : 8'(i));
    for (int f = 0; f < 4; f++) begin
      add(8'(lens[f]));
      for (int j = 0; j < lens[f] + 2; j++) add((f == 3) ? fill_last : 8'hA5);
    end
  endtask

  function automatic void compute(bit m);
    int p, n;
    bit ok;
    n = fbuf.size();
    ref_found = 0; ref_start = 0; det_idx = -1;
    if (!m) begin
      p = 15; ok = 1;
      for (int f = 0; f < 4; f++) begin
        if (p >= n) begin ok = 0; break; end
        p = p + int'(fbuf[p]) + 3;
      end
      if (ok)
        for (int i = p; i + 3 < n; i++)
          if (fbuf[i] == 8'hFF && fbuf[i+1] == 8'hFF && fbuf[i+2] == 8'hFF && fbuf[i+3] == 8'hFF) begin
            ref_found = 1; ref_start = i; det_idx = i + 3; break;
          end
    end else begin
      for (int i = 0; i < n - 1; i++)
        if (fbuf[i] == 8'hFF && fbuf[i+1][7:4] == 4'h3) begin
          ref_found = 1; ref_start = i + 2; det_idx = i + 1; break;
        end
    end
  endfunction

  function automatic void pop_emit();
    int p;
    p = dq.pop_front();
    if (p >= 0 && ref_found && p >= ref_start) begin
      e_vld = 1; e_byte = fbuf[p]; e_idx = p;
    end
  endfunction

  // drive at falling edge, model the next rising edge, compare at next falling edge
  task automatic step(bit st, bit m, bit v, logic [7:0] b, bit l);
    start_i = st; mode_i = m; byte_vld_i = v; byte_i = b; last_i = l;
    e_vld = 0;
    if (st) begin
      dq = '{-1, -1, -1};
      n_acc = 0; m_end = 0; m_flush = 0; e_found = 0; e_miss = 0; emitted = 0;
    end else if (v && !m_end) begin
      dq.push_back(n_acc);
      pop_emit();
      if (ref_found && n_acc == det_idx) begin e_found = 1; e_off = ref_start; end
      if (l) begin
        m_end = 1; m_flush = 3;
        if (!ref_found) e_miss = 1;
      end
      n_acc++;
    end else if (m_flush > 0) begin
      dq.push_back(-1);
      pop_emit();
      m_flush--;
    end
    @(negedge clk);
    chk(pay_vld_o == e_vld, "R4", "pay_vld_o", pay_vld_o, e_vld);
    if (e_vld && pay_vld_o) begin
      emitted++;
      chk(pay_byte_o == e_byte, "R4", "pay_byte_o", pay_byte_o, e_byte);
      chk(pay_idx_o == 16'(e_idx), "R4", "pay_idx_o", pay_idx_o, e_idx);
    end
    chk(found_o == e_found, "R5", "found_o", found_o, e_found);
    if (e_found)
      chk(start_off_o == 16'(e_off), "R5", "start_off_o", start_off_o, e_off);
    chk(miss_o == e_miss, "R6", "miss_o", miss_o, e_miss);
  endtask

  task automatic run_file(bit m, int gap, int junk, bit flip, string tag);
    int n;
    n = fbuf.size();
    compute(m);
    step(1, m, 1, 8'hFF, 0);  // R7: byte offered with start is dropped
    for (int i = 0; i < n; i++) begin
      step(0, flip ? ~m : m, 1, fbuf[i], i == n - 1);  // R8: mode flip ignored
      for (int g = 0; g < gap; g++) step(0, m, 0, 8'hFF, 0);
    end
    for (int j = 0; j < junk; j++) step(0, m, 1, 8'hFF, 1);  // R8
    for (int j = 0; j < 5; j++) step(0, m, 0, 8'h00, 0);
    chk(found_o == ref_found, tag, "final found_o", found_o, ref_found);
    if (ref_found) chk(start_off_o == 16'(ref_start), tag, "final start_off_o", start_off_o, ref_start);
    chk(miss_o == !ref_found, "R6", "final miss_o", miss_o, !ref_found);
    chk(emitted == (ref_found ? n - ref_start : 0), "R4", "payload count", emitted,
        ref_found ? n - ref_start : 0);
  endtask

  initial begin
    #400000;
    if (!fin) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dq = '{-1, -1, -1};
    ref_found = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pay_vld_o && !found_o && !miss_o && start_off_o == 0, "R7", "reset state",
        {pay_vld_o, found_o, miss_o}, 0);

    // R1 R2: header FFs and straddling run ignored, start 41
    hdr(2, 0, 5, 1, 8'hFF);
    add(8'hFF); add(8'h00); add(8'hFF); add(8'hFF); add(8'hFF); add(8'h00);
    for (int i = 0; i < 4; i++) add(8'hFF);
    for (int i = 0; i < 12; i++) add(8'(i * 37 + 5));
    run_file(0, 0, 0, 0, "R2");
    chk(ref_start == 41, "R1", "raw start of header walk file", ref_start, 41);

    // R3: same file in packed mode matches inside header at offsets 3,4
    run_file(1, 0, 0, 0, "R3");
    chk(ref_start == 5, "R3", "packed start inside header", ref_start, 5);

    // R3 R8: packed, FF 20 rejected, mode flipped while streaming
    fbuf.delete();
    add(8'h00); add(8'h11); add(8'hFF); add(8'h20); add(8'hFF); add(8'hFF); add(8'h3A);
    for (int i = 0; i < 10; i++) add(8'(8'hF0 + i));
    run_file(1, 0, 0, 1, "R3");

    // R1 R2 R8: empty fields, preamble right at header end, idle gaps
    hdr(0, 0, 0, 0, 8'hFF);
    for (int i = 0; i < 4; i++) add(8'hFF);
    for (int i = 0; i < 5; i++) add(8'(i + 8'h40));
    run_file(0, 2, 0, 0, "R2");

    // R6 R8: raw miss, junk bytes after end
    hdr(1, 1, 1, 1, 8'hA5);
    add(8'hFF); add(8'hFF); add(8'hFF); add(8'h00); add(8'hFF); add(8'hFF); add(8'hFF);
    run_file(0, 0, 4, 0, "R6");

    // R3 R6: packed, FF only as last byte
    fbuf.delete();
    add(8'h00); add(8'h30); add(8'hFF);
    run_file(1, 0, 0, 0, "R3");

    // R3: packed match in final two bytes, empty payload
    fbuf.delete();
    add(8'h00); add(8'hFF); add(8'h3F);
    run_file(1, 0, 2, 0, "R3");

    // R1 R6: truncated header
    fbuf.delete();
    for (int i = 0; i < 10; i++) add(8'hFF);
    run_file(0, 0, 0, 0, "R1");

    // R2 R4: preamble is the last four bytes, drained by flush
    hdr(0, 0, 0, 0, 8'hA5);
    add(8'h00);
    for (int i = 0; i < 4; i++) add(8'hFF);
    run_file(0, 1, 0, 0, "R2");

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule